// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a 2-bit class code, a sign bit, a signed unbiased exponent and a 64-bit mantissa whose leading one sits in the most significant bit. The numeric value is therefore mantissa × 2^(exponent − 63). The fraction is always dropped toward zero, and no rounding mode takes part. Alongside the integer the block gives an inexact flag and an invalid flag.

Operands that do not fit, infinities and NaNs saturate to the extreme integer of their sign and raise invalid. The bound is asymmetric: −2^31 converts exactly, while +2^31 overflows. The conversion logic is combinational. By default a result register loads it whenever the input strobe is high, so the result, the flags and the output strobe all appear one clock after the operand.

Top module: `flt2int_conv`

## Requirements
- R1: Class codes are 0 = zero, 1 = number, 2 = infinity and 3 = NaN. For a positive number the result is the integer part of mantissa × 2^(exponent − 63), with fraction bits discarded toward zero.
- R2: A zero-class operand gives 0 with both flags clear, whatever the sign, exponent and mantissa are.
- R3: Infinity and NaN operands set invalid, clear inexact and saturate according to the sign.
- R4: A number whose exponent is 32 or more is an overflow, including very large exponents.
- R5: Inexact is set exactly when a nonzero mantissa bit lies below the integer point of an in-range number. This includes the lowest mantissa bit.
- R6: A number with a negative exponent gives 0 with inexact set, for either sign.
- R7: A positive number overflows when its integer magnitude is 2^31 or more. A negative number overflows only when its integer magnitude exceeds 2^31, so −2^31 gives 0x80000000 without invalid.
- R8: A negative in-range number gives the two's-complement negation of its truncated magnitude.
- R9: On any overflow, inexact is cleared and invalid is set. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R10: With the output register on, the result, the flags and `out_valid` follow `in_valid` by one clock. Synchronous active-low reset clears all outputs to 0.
- R11: While `in_valid` is low, the result and the flags keep their last loaded values, and operand changes have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe; loads the result register |
| in_class | input | 2 | Operand class (0 zero, 1 number, 2 infinity, 3 NaN) |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 64 | Mantissa, leading one at bit 63 |
| out_valid | output | 1 | Result strobe |
| out_int | output | 32 | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow or non-number; result saturated |

## Verification
A wrong shift amount or a wrong sticky reduction shows up at the ports in the very next cycle, as a wrong integer or a wrong inexact flag. The vectors put the integer point at several exponents, including one where only the lowest mantissa bit would be lost. An off-by-one in the overflow bound shows only at magnitude 2^31 and just above it. For that reason, both signs are driven at exactly that magnitude, with and without discarded bits. A stuck or leaking load enable shows as a changed result during cycles where the strobe is low.

// File: rtl/ftoi_pkg.sv
// Shared types for the float-to-integer converter.
// Assumes: class codes are fixed by the operand producer.
package ftoi_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } num_class_e;
endpackage

// File: rtl/ftoi_align.sv
// Aligns the mantissa so the integer part lands in the low INT_W bits.
// It also reports the OR of every discarded bit and whether the exponent
// is too large for INT_W bits at all.
// Assumes: the mantissa leading one is at bit MANT_W-1; MANT_W > INT_W.
module ftoi_align #(
    parameter int MANT_W = 64,
    parameter int INT_W  = 32,
    parameter int EXP_W  = 16
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_i,
    output logic [INT_W-1:0]        mag,
    output logic                    sticky,
    output logic                    too_big
);
    localparam int SH_W = $clog2(MANT_W);

    int                sh_amt;
    logic [MANT_W-1:0] lost_bits;

    // Compute the right-shift distance from the exponent.
    always_comb begin
        sh_amt  = (MANT_W - 1) - int'(exp_i);
        too_big = (sh_amt < (MANT_W - INT_W));
    end

    // Shift, clamping distances of MANT_W or more to a full flush.
    always_comb begin
        lost_bits = '0;
        if (sh_amt >= MANT_W) begin
            mag    = '0;
            sticky = |mant;
        end else if (too_big) begin
            mag    = '0;
            sticky = 1'b0;
        end else begin
            mag       = INT_W'(mant >> sh_amt[SH_W-1:0]);
            lost_bits = mant & ~({MANT_W{1'b1}} << sh_amt[SH_W-1:0]);
            sticky    = |lost_bits;
        end
    end
endmodule

// File: rtl/ftoi_pack.sv
// Applies the class, the sign and the asymmetric range bound to an aligned
// magnitude. It yields the final integer and the two exception flags.
// Assumes: mag and sticky are meaningful only when too_big is low.
module ftoi_pack
    import ftoi_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  num_class_e       cls,
    input  logic             sign,
    input  logic [INT_W-1:0] mag,
    input  logic             sticky,
    input  logic             too_big,
    output logic [INT_W-1:0] res,
    output logic             inexact,
    output logic             invalid
);
    localparam logic [INT_W:0] HALF_RANGE = {2'b01, {(INT_W-1){1'b0}}};

    logic mag_ovf;
    logic [INT_W-1:0] sat_val;

    // The magnitude limit is one larger for negative operands.
    always_comb begin
        mag_ovf = ({1'b0, mag} >= (HALF_RANGE + {{INT_W{1'b0}}, sign}));
        sat_val = {sign, {(INT_W-1){~sign}}};
    end

    // Select the result and the flags by class and range.
    always_comb begin
        res     = sat_val;
        inexact = 1'b0;
        invalid = 1'b1;
        case (cls)
            CLS_ZERO: begin
                res     = '0;
                invalid = 1'b0;
            end
            CLS_NUM: begin
                if (!(too_big || mag_ovf)) begin
                    res     = sign ? (~mag + 1'b1) : mag;
                    inexact = sticky;
                    invalid = 1'b0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flt2int_conv.sv
// Top of the float-to-signed-integer converter. The conversion itself is
// combinational. With REG_OUT=1 a result register loads it on in_valid,
// and with REG_OUT=0 the result passes straight through.
// Assumes: synchronous active-low reset; one operand per strobe.
module flt2int_conv
    import ftoi_pkg::*;
#(
    parameter int MANT_W  = 64,
    parameter int INT_W   = 32,
    parameter int EXP_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    num_class_e       cls;
    logic [INT_W-1:0] mag;
    logic             sticky;
    logic             too_big;
    logic [INT_W-1:0] res_c;
    logic             nx_c;
    logic             nv_c;

    // Map the raw class code onto the enumerated type.
    always_comb cls = num_class_e'(in_class);

    ftoi_align #(.MANT_W(MANT_W), .INT_W(INT_W), .EXP_W(EXP_W)) align_i (
        .mant    (in_mant),
        .exp_i   (in_exp),
        .mag     (mag),
        .sticky  (sticky),
        .too_big (too_big)
    );

    ftoi_pack #(.INT_W(INT_W)) pack_i (
        .cls     (cls),
        .sign    (in_sign),
        .mag     (mag),
        .sticky  (sticky),
        .too_big (too_big),
        .res     (res_c),
        .inexact (nx_c),
        .invalid (nv_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Load the result register on the strobe; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid   <= 1'b0;
                    out_int     <= '0;
                    out_inexact <= 1'b0;
                    out_invalid <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_int     <= res_c;
                        out_inexact <= nx_c;
                        out_invalid <= nv_c;
                    end
                end
            end

            // R2
            zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(in_class) == 2'd0)
                |-> (out_int == '0 && !out_inexact && !out_invalid));
            // R3
            nonnum_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(in_class) >= 2'd2) |-> out_invalid);
            // R4
            big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(in_class) == 2'd1 && $past(in_exp) >= INT_W)
                |-> out_invalid);
            // R6
            neg_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(in_class) == 2'd1 && $past(in_exp) < 0)
                |-> (out_int == '0 && out_inexact));
            // R9
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_invalid)
                |-> (!out_inexact &&
                     out_int == {$past(in_sign), {(INT_W-1){~$past(in_sign)}}}));
            // R10
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R11
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(out_int) &&
                               $stable(out_inexact) && $stable(out_invalid)));
        end else begin : g_comb
            // Pass the combinational result straight through.
            always_comb begin
                out_valid   = in_valid;
                out_int     = res_c;
                out_inexact = nx_c;
                out_invalid = nv_c;
            end
        end
    endgenerate
endmodule

// File: tb/flt2int_conv_tb_top.sv
module flt2int_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_class;
    logic        in_sign;
    logic signed [15:0] in_exp;
    logic [63:0] in_mant;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_inexact;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flt2int_conv dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_int(out_int),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  cls;
        logic        sgn;
        logic [15:0] ex;
        logic [63:0] man;
        logic [31:0] res;
        logic        nx;
        logic        nv;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 2'd1, 1'b0, 16'd0,    64'h8000_0000_0000_0000, 32'h0000_0001, 1'b0, 1'b0}, // R1
        '{8'd1, 2'd1, 1'b0, 16'd3,    64'hA000_0000_0000_0000, 32'h0000_000A, 1'b0, 1'b0}, // R1
        '{8'd5, 2'd1, 1'b0, 16'd1,    64'hE000_0000_0000_0000, 32'h0000_0003, 1'b1, 1'b0}, // R5
        '{8'd8, 2'd1, 1'b1, 16'd1,    64'hE000_0000_0000_0000, 32'hFFFF_FFFD, 1'b1, 1'b0}, // R8
        '{8'd8, 2'd1, 1'b1, 16'd4,    64'h8800_0000_0000_0000, 32'hFFFF_FFEF, 1'b0, 1'b0}, // R8
        '{8'd6, 2'd1, 1'b0, 16'hFFFF, 64'h8000_0000_0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R6
        '{8'd6, 2'd1, 1'b1, 16'hFFD8, 64'hC000_0000_0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R6
        '{8'd5, 2'd1, 1'b0, 16'd30,   64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R5
        '{8'd7, 2'd1, 1'b0, 16'd31,   64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R7
        '{8'd7, 2'd1, 1'b1, 16'd31,   64'h8000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R7
        '{8'd7, 2'd1, 1'b1, 16'd31,   64'h8000_0000_8000_0000, 32'h8000_0000, 1'b1, 1'b0}, // R7
        '{8'd9, 2'd1, 1'b1, 16'd31,   64'h8000_0001_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R9
        '{8'd4, 2'd1, 1'b0, 16'd32,   64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R4
        '{8'd4, 2'd1, 1'b1, 16'd200,  64'h8000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R4
        '{8'd3, 2'd2, 1'b0, 16'd0,    64'h0000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R3
        '{8'd3, 2'd3, 1'b1, 16'd7,    64'hC123_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R3
        '{8'd2, 2'd0, 1'b1, 16'd5,    64'hDEAD_BEEF_0000_0001, 32'h0000_0000, 1'b0, 1'b0}, // R2
        '{8'd9, 2'd1, 1'b0, 16'd31,   64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R9
        '{8'd5, 2'd1, 1'b1, 16'd0,    64'h8000_0000_0000_0001, 32'hFFFF_FFFF, 1'b1, 1'b0}  // R5
    };

    task automatic check(input string req, input logic [31:0] got_i, exp_i,
                         input logic got_nx, exp_nx, got_nv, exp_nv,
                         input logic got_v, exp_v);
        checks++;
        if (got_i !== exp_i || got_nx !== exp_nx || got_nv !== exp_nv || got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got int=%h nx=%b nv=%b v=%b, expected int=%h nx=%b nv=%b v=%b",
                     req, got_i, got_nx, got_nv, got_v, exp_i, exp_nx, exp_nv, exp_v);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_class = 2'd0; in_sign = 1'b0;
        in_exp = '0; in_mant = '0;
        repeat (3) @(posedge clk);
        #1 check("R10 reset", out_int, 32'h0, out_inexact, 1'b0, out_invalid, 1'b0, out_valid, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table walk: each result appears one clock after the strobe.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_class = VECS[i].cls;
            in_sign  = VECS[i].sgn;
            in_exp   = VECS[i].ex;
            in_mant  = VECS[i].man;
            @(posedge clk);
            #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), out_int, VECS[i].res,
                     out_inexact, VECS[i].nx, out_invalid, VECS[i].nv, out_valid, 1'b1);
        end

        // R11: operand changes without the strobe leave the outputs alone.
        @(negedge clk);
        in_valid = 1'b0; in_class = 2'd2; in_sign = 1'b0; in_exp = 16'd3;
        in_mant = 64'hA000_0000_0000_0000;
        @(posedge clk);
        #1 check("R11 hold", out_int, 32'hFFFF_FFFF, out_inexact, 1'b1, out_invalid, 1'b0, out_valid, 1'b0);
        @(negedge clk) in_class = 2'd1;
        @(posedge clk);
        #1 check("R11 hold again", out_int, 32'hFFFF_FFFF, out_inexact, 1'b1, out_invalid, 1'b0, out_valid, 1'b0);

        // R10: one strobe gives exactly one result cycle.
        @(negedge clk) in_valid = 1'b1;
        @(negedge clk) in_valid = 1'b0;
        #1 check("R10 latency", out_int, 32'h0000_000A, out_inexact, 1'b0, out_invalid, 1'b0, out_valid, 1'b1);
        @(posedge clk);
        #1 check("R10 strobe drop", out_int, 32'h0000_000A, out_inexact, 1'b0, out_invalid, 1'b0, out_valid, 1'b0);

        // R10: reset in mid-run clears the loaded result.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check("R10 mid reset", out_int, 32'h0, out_inexact, 1'b0, out_invalid, 1'b0, out_valid, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule